// File: doc/BRIEF.md
# Affinity-Targeted SGI Request Decoder

This block takes a 64-bit software-generated-interrupt request word and turns it into per-core pending pulses. The word names one cluster through three upper affinity fields, gives an interrupt number from 0 to 15, and carries a 16-bit bitmap. Each bit of the bitmap picks one core inside the named cluster, found by its lowest affinity value. A core is not chosen by a flat index.

Every core's affinity is a static configuration input. When the request strobe is high, each core compares its three upper affinity levels with the fields in the word. It then checks the bitmap bit that its own level-0 value points at. Every core that matches gets a single-cycle pulse on the pending bit for the named interrupt. One word can reach several cores in one cluster. Cores in other clusters need a separate word.

Top module: `sgi_affinity_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every `sgiPending` bit is 0.
- R2: The request word fields sit at these positions: target bitmap [15:0], level-1 affinity [23:16], interrupt number [27:24], level-2 affinity [39:32], level-3 affinity [55:48]. Each core's affinity input is a 32-bit slice of `coreAffinity` (core i at bits [32*i+31:32*i]) holding level 3 in [31:24], level 2 in [23:16], level 1 in [15:8] and level 0 in [7:0].
- R3: Core i's pending vector sits at `sgiPending[16*i+15:16*i]`, indexed by interrupt number. The core gets exactly one set bit, at the requested number, when all of these hold: its levels 3, 2 and 1 equal the request fields, its level 0 is below 16, and the bitmap bit indexed by its level 0 is 1.
- R4: A mismatch at any one of levels 3, 2 or 1 leaves that core's pending vector all zero.
- R5: A core whose level-0 affinity is 16 or more never receives a pulse.
- R6: A request with an all-zero bitmap sets no pending bit on any core.
- R7: Pending bits appear in the cycle right after the strobe is sampled and last one cycle. With no strobe, all outputs are 0.
- R8: Strobes on consecutive cycles are each delivered in full, in order, one cycle after their own strobe.
- R9: One request can pulse several cores of the same cluster at once, one for each set bitmap bit that matches a core.
- R10: Request bits [31:28], [47:40] and [63:56] have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, one request per cycle |
| reqWord | input | 64 | Request word (fields per R2) |
| coreAffinity | input | 32*NUM_CORES | Per-core affinity, 32 bits per core |
| sgiPending | output | 16*NUM_CORES | Per-core pending pulses, 16 per core |

## Verification
The directed patterns use one fixed core map. In that map, four cores share one cluster, two cores sit in a cluster that differs only at level 1, one core has an out-of-range level-0 value, and one core sits in a separate cluster. Single-bit bitmaps show that a bit selects a core by its affinity and not by its position. Full bitmaps show that several cores of one cluster are reached together. Words that differ from a core at exactly one upper level show that each level is compared. An all-zero bitmap and noise in the reserved bits check R6 and R10. Back-to-back strobes with different interrupt numbers catch any delivery that leaks between cycles. A seeded random phase draws the fields from values that sometimes match, and then swaps in a second core map.

// File: rtl/sgi_dec_pkg.sv
package sgi_dec_pkg;

  localparam int SGI_IDS  = 16;
  localparam int AFF_W    = 8;
  localparam int CORE_AFF_W = 4 * AFF_W;

  typedef struct packed {
    logic [AFF_W-1:0] aff3;
    logic [AFF_W-1:0] aff2;
    logic [AFF_W-1:0] aff1;
    logic [3:0]       sgiId;
    logic [15:0]      targetList;
  } sgiReqT;

  // strobes from control to datapath
  typedef struct packed {
    logic deliver;
  } sgiCtrlT;

  function automatic sgiReqT decodeReq(input logic [63:0] word);
    sgiReqT r;
    r.targetList = word[15:0];
    r.aff1       = word[23:16];
    r.sgiId      = word[27:24];
    r.aff2       = word[39:32];
    r.aff3       = word[55:48];
    return r;
  endfunction

endpackage

// File: rtl/sgi_dec_ctrl.sv
module sgi_dec_ctrl
  import sgi_dec_pkg::*;
(
  input  logic        reqValid,
  input  logic [15:0] targetList,
  output sgiCtrlT     ctrl
);

  // an empty target list is dropped here, so the datapath never loads it
  always_comb begin
    ctrl.deliver = reqValid && (targetList != '0);
  end

endmodule

// File: rtl/sgi_dec_datapath.sv
module sgi_dec_datapath
  import sgi_dec_pkg::*;
#(
  parameter int NUM_CORES = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  sgiCtrlT                       ctrl,
  input  sgiReqT                        req,
  input  logic [CORE_AFF_W*NUM_CORES-1:0] coreAffinity,
  output logic [SGI_IDS*NUM_CORES-1:0]    sgiPending
);

  localparam int SEL_W = $clog2(SGI_IDS);

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic [AFF_W-1:0]   myAff3, myAff2, myAff1, myAff0;
    logic               clusterHit, inRange, listHit;
    logic [SGI_IDS-1:0] pendNext, pendQ;

    always_comb begin
      {myAff3, myAff2, myAff1, myAff0} = coreAffinity[i*CORE_AFF_W +: CORE_AFF_W];
      clusterHit = (myAff3 == req.aff3) && (myAff2 == req.aff2) && (myAff1 == req.aff1);
      inRange    = (myAff0[AFF_W-1:SEL_W] == '0);
      listHit    = req.targetList[myAff0[SEL_W-1:0]];
      pendNext   = '0;
      if (ctrl.deliver && clusterHit && inRange && listHit)
        pendNext[req.sgiId] = 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pendQ <= '0;
      else       pendQ <= pendNext;
    end

    assign sgiPending[i*SGI_IDS +: SGI_IDS] = pendQ;

    AST_ONE_ID_PER_CORE: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(pendQ)); // R3

    AST_ID_FROM_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.deliver |=> (pendQ == '0) || pendQ[$past(req.sgiId)]); // R3

    AST_HIGH_AFF0_SILENT: assert property (@(posedge clk) disable iff (!rstN)
      (coreAffinity[i*CORE_AFF_W + SEL_W +: AFF_W-SEL_W] != '0) |=> (pendQ == '0)); // R5
  end

endmodule

// File: rtl/sgi_affinity_decoder.sv
module sgi_affinity_decoder
  import sgi_dec_pkg::*;
#(
  parameter int NUM_CORES = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               reqValid,
  input  logic [63:0]                        reqWord,
  input  logic [CORE_AFF_W*NUM_CORES-1:0]    coreAffinity,
  output logic [SGI_IDS*NUM_CORES-1:0]       sgiPending
);

  sgiReqT  req;
  sgiCtrlT ctrl;

  assign req = decodeReq(reqWord);

  sgi_dec_ctrl ctrl_i (
    .reqValid   (reqValid),
    .targetList (req.targetList),
    .ctrl       (ctrl)
  );

  sgi_dec_datapath #(.NUM_CORES(NUM_CORES)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .req          (req),
    .coreAffinity (coreAffinity),
    .sgiPending   (sgiPending)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (sgiPending == '0)); // R7

  AST_EMPTY_LIST: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWord[15:0] == '0) |=> (sgiPending == '0)); // R6

endmodule

// File: tb/sgi_affinity_decoder_tb_top.sv
`timescale 1ns/1ps
module sgi_affinity_decoder_tb_top;

  localparam int NC = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic [63:0]     reqWord = '0;
  logic [32*NC-1:0] coreAffinity = '0;
  logic [16*NC-1:0] sgiPending;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;
  bit armed = 0;
  logic [16*NC-1:0] expPend = '0;
  string expTag = "";

  always #2.5 clk = ~clk;

  sgi_affinity_decoder #(.NUM_CORES(NC)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWord(reqWord),
    .coreAffinity(coreAffinity), .sgiPending(sgiPending)
  );

  function automatic logic [31:0] mkAff(input int a3, a2, a1, a0);
    return {a3[7:0], a2[7:0], a1[7:0], a0[7:0]};
  endfunction

  function automatic logic [63:0] mkWord(input int a3, a2, a1, id, input logic [15:0] tl);
    logic [63:0] w = '0;
    w[55:48] = a3[7:0]; w[39:32] = a2[7:0]; w[23:16] = a1[7:0];
    w[27:24] = id[3:0]; w[15:0] = tl;
    return w;
  endfunction

  function automatic logic [16*NC-1:0] model(input logic v, input logic [63:0] w,
                                              input logic [32*NC-1:0] aff);
    logic [16*NC-1:0] e = '0;
    for (int i = 0; i < NC; i++) begin
      logic [31:0] a = aff[32*i +: 32];
      if (v && a[7:0] < 8'd16 && a[31:24] == w[55:48] && a[23:16] == w[39:32] &&
          a[15:8] == w[23:16] && w[a[3:0]])
        e[16*i + int'(w[27:24])] = 1'b1;
    end
    return e;
  endfunction

  task automatic check(input logic [16*NC-1:0] exp, input string tag);
    nChecks++;
    if (sgiPending !== exp) begin
      nFails++;
      $display("FAIL %s: sgiPending=%h expected=%h", tag, sgiPending, exp);
    end
  endtask

  // check the previous request's result, then drive the next one
  task automatic step(input logic v, input logic [63:0] w, input string tag);
    @(negedge clk);
    if (armed) check(expPend, expTag);
    reqValid = v; reqWord = w;
    expPend = model(v, w, coreAffinity);
    expTag = tag;
    armed = 1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog: run hung, expected completion");
    finish();
  end

  initial begin
    logic [63:0] w;
    void'($urandom(32'h5eed_1234));
    // cluster A (1,2,3): cores 0..3 at aff0 0,5,9,15; cluster B (1,2,4): cores 4,5;
    // core 6 in A with aff0 16; core 7 in cluster (0,0,0) aff0 3
    coreAffinity = {mkAff(0,0,0,3), mkAff(1,2,3,16), mkAff(1,2,4,5), mkAff(1,2,4,0),
                    mkAff(1,2,3,15), mkAff(1,2,3,9), mkAff(1,2,3,5), mkAff(1,2,3,0)};
    reqValid = 1'b1; reqWord = mkWord(1,2,3,4,16'hffff);
    repeat (3) @(negedge clk);
    check('0, "R1 during reset");
    rstN = 1'b1;
    reqValid = 1'b0;
    @(negedge clk);
    check('0, "R1 after reset");

    step(1, mkWord(1,2,3,7,16'h0020), "R3 single target aff0=5");
    step(1, mkWord(1,2,3,2,16'h0002), "R3 bit not matching any core");
    step(1, mkWord(1,2,3,15,16'hffff), "R9 whole cluster, R5 core aff0=16 silent");
    step(1, mkWord(1,2,4,0,16'h0021), "R4 level1 differs, cluster B hit");
    step(1, mkWord(1,3,3,1,16'hffff), "R4 level2 mismatch");
    step(1, mkWord(2,2,3,1,16'hffff), "R4 level3 mismatch");
    step(1, mkWord(1,2,3,9,16'h0000), "R6 empty target list");
    step(0, mkWord(1,2,3,9,16'hffff), "R7 no strobe");
    step(1, mkWord(0,0,0,3,16'h0008), "R2 separate cluster at zero affinity");
    w = mkWord(1,2,3,6,16'h8201); w[31:28] = 4'hf; w[47:40] = 8'ha5; w[63:56] = 8'h3c;
    step(1, w, "R10 reserved bits set");
    step(1, mkWord(1,2,3,0,16'h0001), "R8 back-to-back 1");
    step(1, mkWord(1,2,3,1,16'h8000), "R8 back-to-back 2");
    step(1, mkWord(1,2,4,14,16'h0020), "R8 back-to-back 3");
    step(0, '0, "R7 pulse ends");

    for (int n = 0; n < 400; n++) begin
      int a3 = ($urandom % 3 == 0) ? 0 : 1;
      int a2 = ($urandom % 4 == 0) ? int'($urandom % 4) : 2;
      int a1 = 3 + int'($urandom % 2);
      logic [63:0] rw = mkWord(a3, a2, a1, int'($urandom % 16), 16'($urandom));
      rw[31:28] = 4'($urandom);
      if (n == 200) begin
        @(negedge clk);
        if (armed) check(expPend, expTag);
        reqValid = 0; armed = 0;
        coreAffinity = {mkAff(1,2,4,7), mkAff(1,2,3,12), mkAff(1,2,3,3), mkAff(1,2,4,3),
                        mkAff(1,0,3,1), mkAff(0,2,3,2), mkAff(1,2,3,40), mkAff(1,2,3,11)};
      end
      step(($urandom % 5) != 0, rw, "R3 random request");
    end
    step(0, '0, "R7 final idle");
    @(negedge clk);
    check(expPend, expTag);
    finish();
  end

endmodule